// File: doc/BRIEF.md
# Four-Lane Integer Vector ALU

This unit performs one integer operation across four 32-bit lanes at a time. The lanes are named x, y, z and w. Lane x occupies bits [31:0] of every vector port, followed by y, z and w toward the top bits. Each operation takes a 5-bit opcode and up to three source vectors (A, B, C), qualified by a valid strobe. It returns a four-lane result with its own valid strobe.

With the default `REG_OUT = 1`, the result and the illegal-opcode flag are registered, so they appear one cycle after the request is accepted. Between requests the last result stays on the output. With `REG_OUT = 0` the unit is purely combinational. Arithmetic wraps at 32 bits and does not depend on signedness, except where an operation is explicitly signed or unsigned. Each set-on-compare operation returns a full lane mask, so the result can feed bitwise selects directly.

Top module: `vec4_int_alu`

## Requirements
- R1: Opcode 0 adds A+B, opcode 1 multiplies A*B and opcode 2 computes the multiply-add A*B+C, each per lane. Only the low 32 bits are kept, and the product is cut to 32 bits before C is added.
- R2: Opcodes 18..23 write 0xFFFFFFFF to a lane whose condition holds and 0 otherwise. The conditions are: 18 signed A<B, 19 unsigned A<B, 20 signed A>=B, 21 unsigned A>=B, 22 A==B, 23 A!=B.
- R3: Opcode 14 shifts left, 15 shifts right arithmetically and 16 shifts right logically. Every lane of A shifts by the low 5 bits of lane x of B, so amounts of 32 or more wrap modulo 32, and lanes y, z and w of B have no effect.
- R4: Opcode 5 returns, for each lane of A read as signed, 0xFFFFFFFF for a negative value, 1 for a positive value and 0 for zero.
- R5: Opcode 17 returns B's lane where A's lane is nonzero and C's lane where it is zero.
- R6: Opcode 3 negates A in two's complement and opcode 4 returns the absolute value of A. Both map 0x80000000 to 0x80000000.
- R7: Opcodes 6 and 7 give the signed and unsigned minimum of A and B. Opcodes 8 and 9 give the signed and unsigned maximum.
- R8: Opcode 10 returns ~A. Opcodes 11, 12 and 13 return A&B, A|B and A^B.
- R9: Opcodes 24..31 are undefined. They produce an all-zero result, and `illegal` is high alongside that result's `out_valid`. `illegal` is low for every defined opcode and whenever `out_valid` is low.
- R10: `out_valid` follows `in_valid` exactly one cycle later, together with the result of that request. While `in_valid` is low the previous result is held.
- R11: During reset, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 5 | Operation select |
| src_a | input | 128 | Source A, lane x in bits [31:0] |
| src_b | input | 128 | Source B; lane x also gives the shift amount |
| src_c | input | 128 | Source C (multiply-add addend, select false value) |
| out_valid | output | 1 | Result strobe |
| result | output | 128 | Four-lane result |
| illegal | output | 1 | Undefined opcode seen on this result |

## Verification
The assertions check the following on every cycle:
- the one-cycle lag of `out_valid`;
- that the result holds while no request arrives;
- that an illegal flag always comes with a zero result and only for opcodes 24..31;
- that compare results are pure lane masks;
- that sign results are one of three values.

Only the bench's scenarios can show that each lane carries the right value. These scenarios cover wrap-around in multiply-add, the 0x80000000 corner of negate and absolute value, shift amounts taken from lane x alone and wrapping modulo 32, and the signed-versus-unsigned split in min, max and compares.

// File: rtl/vec4_int_alu.sv
module vec4_int_alu #(
  parameter int LANES   = 4,
  parameter int W       = 32,
  parameter int OPW     = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [OPW-1:0]       opcode,
  input  logic [LANES*W-1:0]   src_a,
  input  logic [LANES*W-1:0]   src_b,
  input  logic [LANES*W-1:0]   src_c,
  output logic                 out_valid,
  output logic [LANES*W-1:0]   result,
  output logic                 illegal
);
  localparam int SHW = $clog2(W);
  localparam int VW  = LANES * W;

  localparam logic [OPW-1:0] OP_ADD  = OPW'(0);
  localparam logic [OPW-1:0] OP_MUL  = OPW'(1);
  localparam logic [OPW-1:0] OP_MAD  = OPW'(2);
  localparam logic [OPW-1:0] OP_NEG  = OPW'(3);
  localparam logic [OPW-1:0] OP_ABS  = OPW'(4);
  localparam logic [OPW-1:0] OP_SGN  = OPW'(5);
  localparam logic [OPW-1:0] OP_SMIN = OPW'(6);
  localparam logic [OPW-1:0] OP_UMIN = OPW'(7);
  localparam logic [OPW-1:0] OP_SMAX = OPW'(8);
  localparam logic [OPW-1:0] OP_UMAX = OPW'(9);
  localparam logic [OPW-1:0] OP_NOT  = OPW'(10);
  localparam logic [OPW-1:0] OP_AND  = OPW'(11);
  localparam logic [OPW-1:0] OP_OR   = OPW'(12);
  localparam logic [OPW-1:0] OP_XOR  = OPW'(13);
  localparam logic [OPW-1:0] OP_SHL  = OPW'(14);
  localparam logic [OPW-1:0] OP_ASR  = OPW'(15);
  localparam logic [OPW-1:0] OP_LSR  = OPW'(16);
  localparam logic [OPW-1:0] OP_SEL  = OPW'(17);
  localparam logic [OPW-1:0] OP_SLT  = OPW'(18);
  localparam logic [OPW-1:0] OP_ULT  = OPW'(19);
  localparam logic [OPW-1:0] OP_SGE  = OPW'(20);
  localparam logic [OPW-1:0] OP_UGE  = OPW'(21);
  localparam logic [OPW-1:0] OP_EQ   = OPW'(22);
  localparam logic [OPW-1:0] OP_NE   = OPW'(23);

  logic [VW-1:0]  comb_res;
  logic [SHW-1:0] shamt;
  logic           bad_op;

  assign shamt  = src_b[SHW-1:0];
  assign bad_op = opcode > OP_NE;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [W-1:0] a, b, c, r, prod;
    logic         slt, ult;

    assign a    = src_a[i*W +: W];
    assign b    = src_b[i*W +: W];
    assign c    = src_c[i*W +: W];
    assign prod = a * b;
    assign slt  = $signed(a) < $signed(b);
    assign ult  = a < b;

    always_comb begin
      case (opcode)
        OP_ADD:  r = a + b;
        OP_MUL:  r = prod;
        OP_MAD:  r = prod + c;
        OP_NEG:  r = -a;
        OP_ABS:  r = a[W-1] ? -a : a;
        OP_SGN:  r = a[W-1] ? '1 : ((a != '0) ? W'(1) : '0);
        OP_SMIN: r = slt ? a : b;
        OP_UMIN: r = ult ? a : b;
        OP_SMAX: r = slt ? b : a;
        OP_UMAX: r = ult ? b : a;
        OP_NOT:  r = ~a;
        OP_AND:  r = a & b;
        OP_OR:   r = a | b;
        OP_XOR:  r = a ^ b;
        OP_SHL:  r = a << shamt;
        OP_ASR:  r = $signed(a) >>> shamt;
        OP_LSR:  r = a >> shamt;
        OP_SEL:  r = (a != '0) ? b : c;
        OP_SLT:  r = {W{slt}};
        OP_ULT:  r = {W{ult}};
        OP_SGE:  r = {W{~slt}};
        OP_UGE:  r = {W{~ult}};
        OP_EQ:   r = {W{a == b}};
        OP_NE:   r = {W{a != b}};
        default: r = '0;
      endcase
    end

    assign comb_res[i*W +: W] = r;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        illegal   <= 1'b0;
        result    <= '0;
      end else begin
        out_valid <= in_valid;
        illegal   <= in_valid & bad_op;
        if (in_valid) result <= comb_res;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign illegal   = in_valid & bad_op;
    assign result    = comb_res;
  end
endmodule

module vec4_int_alu_chk #(
  parameter int LANES   = 4,
  parameter int W       = 32,
  parameter int OPW     = 5,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [OPW-1:0]     opcode,
  input logic               out_valid,
  input logic [LANES*W-1:0] result,
  input logic               illegal
);
  localparam logic [OPW-1:0] C_SGN   = OPW'(5);
  localparam logic [OPW-1:0] C_CMP_LO = OPW'(18);
  localparam logic [OPW-1:0] C_CMP_HI = OPW'(23);

  if (REG_OUT) begin : g_chk
    p_valid_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

    p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (out_valid && result == '0));

    p_illegal_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (illegal == ($past(opcode) > C_CMP_HI)));

    for (genvar i = 0; i < LANES; i++) begin : g_ln
      p_cmp_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode >= C_CMP_LO && opcode <= C_CMP_HI) |=>
        (result[i*W +: W] == '0 || result[i*W +: W] == '1));

      p_sign_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == C_SGN) |=>
        (result[i*W +: W] == '0 || result[i*W +: W] == '1 ||
         result[i*W +: W] == W'(1)));
    end
  end
endmodule

bind vec4_int_alu vec4_int_alu_chk #(
  .LANES(LANES), .W(W), .OPW(OPW), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .out_valid(out_valid), .result(result), .illegal(illegal)
);

// File: tb/tb_vec4_int_alu.sv
`timescale 1ns/1ps
module tb_vec4_int_alu;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [4:0]   opcode = '0;
  logic [127:0] src_a = '0, src_b = '0, src_c = '0;
  logic         out_valid, illegal;
  logic [127:0] result;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  typedef struct packed { logic ill; logic [127:0] res; logic [4:0] op; } exp_t;
  exp_t sb[$];
  logic [127:0] last_res = '0;

  always #2.5 clk = ~clk;

  vec4_int_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  function automatic string req_of(logic [4:0] op);
    if (op <= 2) return "R1";
    if (op == 3 || op == 4) return "R6";
    if (op == 5) return "R4";
    if (op >= 6 && op <= 9) return "R7";
    if (op >= 10 && op <= 13) return "R8";
    if (op >= 14 && op <= 16) return "R3";
    if (op == 17) return "R5";
    if (op >= 18 && op <= 23) return "R2";
    return "R9";
  endfunction

  function automatic logic [127:0] v4(logic [31:0] x, y, z, w);
    return {w, z, y, x};
  endfunction

  function automatic exp_t model(logic [4:0] op, logic [127:0] a, b, c);
    exp_t e;
    int unsigned s;
    e.op = op; e.ill = 1'b0; e.res = '0;
    s = b[31:0] % 32;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] x, y, z, o;
      longint sx, sy;
      x = a[i*32 +: 32]; y = b[i*32 +: 32]; z = c[i*32 +: 32];
      sx = longint'($signed(x)); sy = longint'($signed(y));
      o = '0;
      case (op)
        0:  o = 32'(64'(x) + 64'(y));
        1:  o = 32'(64'(x) * 64'(y));
        2:  o = 32'(64'(x) * 64'(y)) + z;
        3:  o = 32'(-sx);
        4:  o = (sx < 0) ? 32'(-sx) : x;
        5:  o = (sx < 0) ? 32'hFFFF_FFFF : ((sx > 0) ? 32'd1 : 32'd0);
        6:  o = (sx < sy) ? x : y;
        7:  o = (x < y) ? x : y;
        8:  o = (sx > sy) ? x : y;
        9:  o = (x > y) ? x : y;
        10: o = ~x;
        11: o = x & y;
        12: o = x | y;
        13: o = x ^ y;
        14: o = x << s;
        15: o = 32'(sx >>> s);
        16: o = x >> s;
        17: o = (x != 0) ? y : z;
        18: o = (sx < sy)  ? '1 : '0;
        19: o = (x < y)    ? '1 : '0;
        20: o = (sx >= sy) ? '1 : '0;
        21: o = (x >= y)   ? '1 : '0;
        22: o = (x == y)   ? '1 : '0;
        23: o = (x != y)   ? '1 : '0;
        default: e.ill = 1'b1;
      endcase
      e.res[i*32 +: 32] = o;
    end
    return e;
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [4:0] op, logic [127:0] a, b, c);
    @(negedge clk);
    opcode = op; src_a = a; src_b = b; src_c = c; in_valid = 1'b1;
    sb.push_back(model(op, a, b, c));
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_a = ~src_a; opcode = 5'd0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check("R10", {127'd0, out_valid}, 128'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(req_of(e.op), result, e.res);
          check("R9", {127'd0, illegal}, {127'd0, e.ill});
          last_res = e.res;
        end
      end else begin
        check("R10", result, last_res);
        check("R9", {127'd0, illegal}, 128'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", result, '0);
    check("R11", {126'd0, out_valid, illegal}, 128'd0);
    rst_n = 1'b1;
    idle(2);

    // R1 add/mul/mad wrap, product truncated before add
    issue(0, v4(32'hFFFF_FFFF, 5, 32'h8000_0000, 0), v4(1, 7, 32'h8000_0000, 0), '0);
    issue(1, v4(32'h0001_0000, 3, 32'hFFFF_FFFF, 32'h1234), v4(32'h0001_0000, 5, 32'hFFFF_FFFF, 2), '0);
    issue(2, v4(32'h0001_0000, 3, 32'hFFFF_FFFF, 0), v4(32'h0001_0000, 4, 2, 9),
          v4(5, 1, 3, 32'hFFFF_FFFF));
    idle(1);
    // R6 negate/abs incl. most negative
    issue(3, v4(32'h8000_0000, 1, 0, 32'hFFFF_FFFE), '0, '0);
    issue(4, v4(32'h8000_0000, 32'hFFFF_FFFF, 0, 7), '0, '0);
    // R4 sign
    issue(5, v4(32'h8000_0000, 0, 32'h7FFF_FFFF, 1), '0, '0);
    // R7 signed vs unsigned min/max
    for (int op = 6; op <= 9; op++)
      issue(5'(op), v4(32'hFFFF_FFFF, 3, 32'h8000_0000, 5), v4(1, 3, 32'h7FFF_FFFF, 2), '0);
    // R8 bitwise
    for (int op = 10; op <= 13; op++)
      issue(5'(op), v4(32'hF0F0_F0F0, 32'h1234_5678, 0, 32'hFFFF_FFFF),
            v4(32'hFF00_FF00, 32'h0F0F_0F0F, 32'hAAAA_AAAA, 1), '0);
    idle(3);
    // R3 shifts: amount from lane x only, modulo 32
    for (int op = 14; op <= 16; op++) begin
      issue(5'(op), v4(32'h8000_0001, 32'hF000_000F, 32'h1, 32'h7FFF_FFFF), v4(4, 1, 2, 3), '0);
      issue(5'(op), v4(32'h8000_0001, 32'hF000_000F, 32'h1, 32'h7FFF_FFFF), v4(31, 0, 0, 0), '0);
      issue(5'(op), v4(32'h8000_0001, 32'hF000_000F, 32'h1, 32'h7FFF_FFFF), v4(32, 9, 9, 9), '0);
      issue(5'(op), v4(32'h8000_0001, 32'hF000_000F, 32'h1, 32'h7FFF_FFFF), v4(37, 0, 31, 16), '0);
    end
    // R5 select
    issue(17, v4(0, 1, 32'h8000_0000, 0), v4(11, 22, 33, 44), v4(55, 66, 77, 88));
    // R2 compares at boundaries
    for (int op = 18; op <= 23; op++)
      issue(5'(op), v4(32'hFFFF_FFFF, 5, 32'h8000_0000, 9), v4(1, 5, 32'h7FFF_FFFF, 8), '0);
    idle(2);
    // R9 undefined opcodes
    issue(24, v4(1, 2, 3, 4), v4(1, 2, 3, 4), '1);
    issue(31, '1, '1, '1);
    issue(0, v4(1, 2, 3, 4), v4(10, 20, 30, 40), '0);
    idle(2);
    // mixed random traffic across all opcodes with gaps
    for (int k = 0; k < 320; k++) begin
      logic [127:0] a, b, c;
      rng = nxt(rng); a[31:0] = rng;   rng = nxt(rng); a[63:32] = rng;
      rng = nxt(rng); a[95:64] = rng;  rng = nxt(rng); a[127:96] = (k % 5 == 0) ? 32'h0 : rng;
      rng = nxt(rng); b[31:0] = rng;   rng = nxt(rng); b[63:32] = (k % 3 == 0) ? a[63:32] : rng;
      rng = nxt(rng); b[95:64] = rng;  rng = nxt(rng); b[127:96] = rng;
      rng = nxt(rng); c = {rng, ~rng, rng ^ 32'h5A5A_5A5A, rng + 1};
      issue(5'(k % 32), a, b, c);
      if (k % 7 == 6) idle(1 + k % 3);
    end
    idle(4);
    check("R10", 128'(sb.size()), 128'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule